// File: doc/BRIEF.md
# Two-Axis Shift-Accumulate Recombiner for Binary Column Sums

This block assembles a signed or unsigned multibit dot-product value from digitized one-bit column results. Each weight bit of the matrix operand sits in its own column, and the input operand is applied one bit plane per step, least significant plane first. On every step the block receives one converted code per weight-bit column. It scales each code by two to the power of its weight-bit index plus the current plane index, and adds all of those terms into a running sum. When the last plane has been added it raises a one-cycle completion strobe, and the final sum stays on the output.

An operation begins with a start pulse. The pulse clears the sum and latches the weight precision, the input precision and the sign mode. Codes are accepted only while an operation is in progress and the valid input is high. Cycles with valid low do not advance the plane count. The converted codes are already quantized, so the result is a weighted sum of codes and not an exact integer product.

Top module: `recomb_shift_acc`

## Requirements
- R1: A start pulse clears the result to 0 at the next clock edge, raises busy at that edge and latches the precisions and the sign mode. A start pulse that arrives while busy abandons the running operation, and that operation produces no done.
- R2: Each beat accepted while busy (col_valid high, start low) belongs to plane j. j counts from 0 at the first accepted beat after start. For each column i below the weight precision, the beat adds the unsigned code in col_codes bits [8i+7:8i] times 2^(i+j).
- R3: Columns whose index is at or above the latched weight precision contribute nothing.
- R4: With signed_mode high, a term is subtracted when exactly one of these holds: i is the top weight column (precision-1), or j is the last plane (precision-1). Otherwise it is added. With signed_mode low, every term is added.
- R5: done is high for exactly one cycle, directly after the edge that absorbs plane (input precision-1). Busy is low in that cycle. The result then holds until the next start.
- R6: Cycles with col_valid low during an operation do not advance the plane count and do not change the result.
- R7: Codes presented while not busy are ignored, including on the start cycle itself. The result does not change and done stays low.
- R8: A precision field (4 bits) of 0 is treated as 1, and a value above 8 is treated as 8.
- R9: The 25-bit result never overflows at 8-bit weight and input precision, even with all codes at 255.
- R10: After reset, result is 0 and busy and done are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a new operation, clearing the sum |
| wprec_cfg | input | 4 | Weight precision, 1 to 8 |
| xprec_cfg | input | 4 | Input precision = number of planes, 1 to 8 |
| signed_mode | input | 1 | Treat both operands as two's complement |
| col_valid | input | 1 | col_codes carries one plane's column codes |
| col_codes | input | 64 | Eight 8-bit unsigned column codes, column i in bits [8i+7:8i] |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle strobe after the final plane |
| result | output | 25 | Signed accumulated sum |

## Verification
Random codes at mixed precisions, in both sign modes, test the scaling by combined bit position against a weighted sum computed in the bench. Codes of all 255 at full precision show whether the width holds the largest unsigned value and whether the signed sign rule cancels terms correctly. Garbage codes on unused columns, gap cycles, idle beats and the start cycle tell apart a block that respects qualification from one that absorbs stray data. Precision fields of 0 and above 8, together with a restart in mid-operation, expose wrong clamping and a leaked done from an abandoned operation.

// File: rtl/recomb_pkg.sv
// Package: shared helpers for the shift-accumulate recombiner.
// Assumes precision fields are small unsigned integers.
package recomb_pkg;
    // Map a raw precision field onto the legal range 1..maxp.
    function automatic int clamp_prec(int v, int maxp);
        if (v < 1) return 1;
        if (v > maxp) return maxp;
        return v;
    endfunction
endpackage

// File: rtl/recomb_ctrl.sv
// Module: recomb_ctrl
// Sequences one operation: latches the configuration on start and counts
// accepted planes. It flags the last plane and pulses done after that plane.
// Assumes start has priority over col_valid.
module recomb_ctrl #(
    parameter int MAX_WB = 8,
    parameter int MAX_XB = 8,
    parameter int CFG_W  = 4,
    parameter int STEP_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              col_valid,
    input  logic [CFG_W-1:0]  wprec_cfg,
    input  logic [CFG_W-1:0]  xprec_cfg,
    input  logic              signed_mode,
    output logic              busy,
    output logic              done,
    output logic              take,
    output logic              last_plane,
    output logic [STEP_W-1:0] plane,
    output logic [CFG_W-1:0]  wprec_q,
    output logic [CFG_W-1:0]  xprec_q,
    output logic              sgn_q
);
    // Decode an accepted beat and whether it carries the final plane.
    always_comb begin
        take       = busy & col_valid & ~start;
        last_plane = (CFG_W'(plane) == (xprec_q - 1'b1));
    end

    // Track operation state, plane index and latched configuration.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy    <= 1'b0;
            done    <= 1'b0;
            plane   <= '0;
            wprec_q <= CFG_W'(1);
            xprec_q <= CFG_W'(1);
            sgn_q   <= 1'b0;
        end else begin
            done <= 1'b0;
            if (start) begin
                busy    <= 1'b1;
                plane   <= '0;
                wprec_q <= CFG_W'(recomb_pkg::clamp_prec(int'(wprec_cfg), MAX_WB));
                xprec_q <= CFG_W'(recomb_pkg::clamp_prec(int'(xprec_cfg), MAX_XB));
                sgn_q   <= signed_mode;
            end else if (take) begin
                if (last_plane) begin
                    busy  <= 1'b0;
                    done  <= 1'b1;
                    plane <= '0;
                end else begin
                    plane <= plane + 1'b1;
                end
            end
        end
    end

    // R5
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R2
    plane_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (CFG_W'(plane) < xprec_q));
endmodule

// File: rtl/recomb_term.sv
// Module: recomb_term
// Turns one column code into a signed term scaled by 2^(COL+plane).
// The sign follows the two's-complement MSB rule. Columns at or above the
// weight precision yield zero. Assumes an unsigned code.
module recomb_term #(
    parameter int COL    = 0,
    parameter int CODE_W = 8,
    parameter int CFG_W  = 4,
    parameter int STEP_W = 3,
    parameter int ACC_W  = 25
) (
    input  logic [CODE_W-1:0]        code,
    input  logic [STEP_W-1:0]        plane,
    input  logic                     last_plane,
    input  logic [CFG_W-1:0]         wprec,
    input  logic                     sgn,
    output logic signed [ACC_W-1:0]  term
);
    logic [ACC_W-1:0] mag;
    logic             active;
    logic             top_col;

    // Scale the code and apply the column enable and the sign rule.
    always_comb begin
        active  = (CFG_W'(COL) < wprec);
        top_col = (CFG_W'(COL) == (wprec - 1'b1));
        mag     = ACC_W'(code) << (COL + int'(plane));
        if (!active)
            term = '0;
        else if (sgn && (top_col ^ last_plane))
            term = -$signed(mag);
        else
            term = $signed(mag);
    end
endmodule

// File: rtl/recomb_shift_acc.sv
// Module: recomb_shift_acc (top)
// Takes one plane of column codes per accepted beat. It adds the scaled
// column terms across columns and into a running sum across planes.
// Assumes codes are settled whenever col_valid is high.
module recomb_shift_acc #(
    parameter int CODE_W = 8,
    parameter int MAX_WB = 8,
    parameter int MAX_XB = 8,
    localparam int MAXP   = (MAX_WB > MAX_XB) ? MAX_WB : MAX_XB,
    localparam int CFG_W  = $clog2(MAXP + 1),
    localparam int STEP_W = (MAX_XB > 1) ? $clog2(MAX_XB) : 1,
    localparam int ACC_W  = CODE_W + MAX_WB + MAX_XB + 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     start,
    input  logic [CFG_W-1:0]         wprec_cfg,
    input  logic [CFG_W-1:0]         xprec_cfg,
    input  logic                     signed_mode,
    input  logic                     col_valid,
    input  logic [MAX_WB*CODE_W-1:0] col_codes,
    output logic                     busy,
    output logic                     done,
    output logic signed [ACC_W-1:0]  result
);
    logic              take;
    logic              last_plane;
    logic [STEP_W-1:0] plane;
    logic [CFG_W-1:0]  wprec_q;
    logic [CFG_W-1:0]  xprec_q;
    logic              sgn_q;
    logic signed [ACC_W-1:0] terms [MAX_WB];
    logic signed [ACC_W-1:0] plane_sum;

    recomb_ctrl #(
        .MAX_WB(MAX_WB), .MAX_XB(MAX_XB), .CFG_W(CFG_W), .STEP_W(STEP_W)
    ) ctrl_i (
        .clk(clk), .rst_n(rst_n), .start(start), .col_valid(col_valid),
        .wprec_cfg(wprec_cfg), .xprec_cfg(xprec_cfg),
        .signed_mode(signed_mode), .busy(busy), .done(done), .take(take),
        .last_plane(last_plane), .plane(plane), .wprec_q(wprec_q),
        .xprec_q(xprec_q), .sgn_q(sgn_q)
    );

    for (genvar c = 0; c < MAX_WB; c++) begin : g_col
        recomb_term #(
            .COL(c), .CODE_W(CODE_W), .CFG_W(CFG_W),
            .STEP_W(STEP_W), .ACC_W(ACC_W)
        ) term_i (
            .code(col_codes[c*CODE_W +: CODE_W]), .plane(plane),
            .last_plane(last_plane), .wprec(wprec_q), .sgn(sgn_q),
            .term(terms[c])
        );
    end

    // Add all column terms of the current plane.
    always_comb begin
        plane_sum = '0;
        for (int c = 0; c < MAX_WB; c++)
            plane_sum = plane_sum + terms[c];
    end

    // Clear on start and absorb one plane per accepted beat.
    always_ff @(posedge clk) begin
        if (!rst_n)
            result <= '0;
        else if (start)
            result <= '0;
        else if (take)
            result <= result + plane_sum;
    end

    // R1
    start_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (busy && result == '0));

    // R7
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> $stable(result));

    // R5
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    // R6
    gap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !col_valid && !start) |=> ($stable(result) && busy));
endmodule

// File: tb/recomb_shift_acc_tb_top.sv
// Bench: scoreboard. The driver pushes expected sums; the monitor pops them on done.
module recomb_shift_acc_tb_top;
    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               start = 1'b0;
    logic [3:0]         wprec_cfg = 4'd1;
    logic [3:0]         xprec_cfg = 4'd1;
    logic               signed_mode = 1'b0;
    logic               col_valid = 1'b0;
    logic [63:0]        col_codes = '0;
    logic               busy;
    logic               done;
    logic signed [24:0] result;

    int checks = 0;
    int errors = 0;
    longint exp_q[$];
    string  tag_q[$];

    always #2.5 clk = ~clk;

    recomb_shift_acc dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .wprec_cfg(wprec_cfg),
        .xprec_cfg(xprec_cfg), .signed_mode(signed_mode),
        .col_valid(col_valid), .col_codes(col_codes),
        .busy(busy), .done(done), .result(result)
    );

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int clampv(int v);
        if (v < 1) return 1;
        if (v > 8) return 8;
        return v;
    endfunction

    function automatic logic [63:0] rnd64();
        return {$urandom, $urandom};
    endfunction

    // Monitor: compare every done against the oldest expected item.
    always @(negedge clk) begin
        if (rst_n && done) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R1 done from abandoned or unknown operation", 1, 0);
            end else begin
                longint e;
                string  t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check(longint'(result) == e, t, longint'(result), e);
            end
        end
    end

    // Driver: run one operation. pat 0 = random codes, pat 1 = all 255.
    task automatic run_op(input int w, input int x, input bit sg, input int pat,
                          input bit gaps, input string tag);
        int we = clampv(w);
        int xe = clampv(x);
        longint acc = 0;
        start       = 1'b1;
        wprec_cfg   = 4'(w);
        xprec_cfg   = 4'(x);
        signed_mode = sg;
        col_valid   = 1'b1;
        col_codes   = rnd64();
        @(negedge clk);
        start = 1'b0;
        for (int j = 0; j < xe; j++) begin
            if (gaps) begin
                col_valid = 1'b0;
                col_codes = rnd64();
                @(negedge clk);
            end
            col_codes = (pat == 1) ? {64{1'b1}} : rnd64();
            col_valid = 1'b1;
            for (int i = 0; i < we; i++) begin
                longint code = longint'((col_codes >> (8 * i)) & 64'hFF);
                longint t = code <<< (i + j);
                if (sg && ((i == we - 1) != (j == xe - 1))) acc -= t;
                else acc += t;
            end
            if (j == xe - 1) begin
                exp_q.push_back(acc);
                tag_q.push_back(tag);
            end
            @(negedge clk);
        end
        col_valid = 1'b0;
        check(done == 1'b1 && busy == 1'b0, "R5 done right after last plane", done, 1);
        @(negedge clk);
        check(done == 1'b0, "R5 done lasts one cycle", done, 0);
        check(longint'(result) == acc, "R5 result holds after done", longint'(result), acc);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(result == 0 && busy == 0 && done == 0, "R10 reset state", result, 0);

        run_op(4, 4, 1'b0, 0, 1'b0, "R2 unsigned 4x4 random");
        run_op(8, 3, 1'b0, 0, 1'b1, "R6 unsigned 8x3 with gaps");
        run_op(3, 5, 1'b0, 0, 1'b0, "R3 upper columns ignored");
        run_op(5, 6, 1'b1, 0, 1'b0, "R4 signed 5x6 random");
        run_op(8, 8, 1'b1, 0, 1'b1, "R4 signed 8x8 random");
        run_op(8, 8, 1'b0, 1, 1'b0, "R9 unsigned all-255 full precision");
        run_op(8, 8, 1'b1, 1, 1'b0, "R4 signed all-255 full precision");
        run_op(1, 1, 1'b1, 0, 1'b0, "R4 signed 1x1");
        run_op(0, 0, 1'b0, 0, 1'b0, "R8 zero precision clamps to 1");
        run_op(15, 12, 1'b0, 1, 1'b0, "R8 large precision clamps to 8");

        // R7: stray codes while idle leave the result alone.
        begin
            logic signed [24:0] held;
            held = result;
            col_valid = 1'b1;
            for (int k = 0; k < 3; k++) begin
                col_codes = rnd64();
                @(negedge clk);
                check(result == held && done == 1'b0, "R7 idle codes ignored", result, held);
            end
            col_valid = 1'b0;
        end

        // R1: restart in mid-operation, only the second operation may finish.
        start = 1'b1; wprec_cfg = 4'd6; xprec_cfg = 4'd6; signed_mode = 1'b0;
        col_valid = 1'b0;
        @(negedge clk);
        start = 1'b0; col_valid = 1'b1;
        for (int k = 0; k < 2; k++) begin
            col_codes = rnd64();
            @(negedge clk);
        end
        run_op(6, 2, 1'b1, 0, 1'b0, "R1 restart discards partial sum");

        repeat (4) @(negedge clk);
        check(exp_q.size() == 0, "R5 every expected done seen", exp_q.size(), 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule